// File: doc/BRIEF.md
# Sensor FIFO Status Flag Unit

This block keeps the fill level of a sample FIFO that a sensor front end fills at a fixed output data rate. Each stored entry is one sample record: a tag byte followed by six data bytes. The block does not hold the records. It sees a strobe for every record written and a strobe for every record consumed, and from these it keeps a 10-bit count of unread records. From that count it derives the watermark, the full and the "full on the next sample" flags.

The count and the flags are packed into two read-only status bytes. A small register read port returns these bytes at their addresses. The same port drives the clear-on-read behaviour of two sticky flags: the latched overrun flag and the batch-counter threshold flag.

A separate 11-bit batch counter advances on its own increment strobe. It raises a sticky flag each time it reaches a programmable threshold. The FIFO capacity is a parameter, 512 records by default. When a write arrives while the FIFO is full, the oldest record is overwritten.

Top module: `sfifo_status_unit`

## Requirements
- R1: The unread count is 10 bits wide. A write strobe adds one and an effective read strobe subtracts one. Count bits [7:0] form status byte 1, which is at address 0x3A. Count bits [9:8] sit in bits [1:0] of status byte 2.
- R2: Status byte 2, which is at address 0x3B, is laid out as follows. Bit 7 is the watermark flag. Bit 6 is the full flag. Bit 5 is the full-next flag. Bit 4 is the batch flag. Bit 3 is the latched overrun flag. Bit 2 always reads 0. Bits [1:0] are count[9:8].
- R3: The watermark flag is 1 exactly when the count is greater than or equal to the 9-bit watermark input.
- R4: The full flag is 1 exactly while the count equals the capacity CAP.
- R5: The full-next flag is 1 exactly while the count equals CAP-1.
- R6: An overrun is a write while the count equals CAP with no effective read in the same cycle. An overrun sets the latched overrun flag. The flag holds until a register read at address 0x3B clears it. If an overrun and that read fall in the same cycle, the flag stays set.
- R7: Each increment strobe advances an 11-bit batch counter. When the incremented value equals the 11-bit threshold, the batch flag sets and the counter restarts at 0. A threshold of 0 never sets the flag.
- R8: A register read at address 0x0B or 0x0C clears the batch flag. If the flag sets in the same cycle as such a read, it stays set.
- R9: When the read enable is high, read data is status byte 1 at address 0x3A and status byte 2 at address 0x3B. Read data is 0 at any other address and whenever the read enable is low. The data returned shows the flags as they were before that read's clear takes effect.
- R10: After a synchronous reset the count, all flags and the batch counter are 0.
- R11: A write at full overwrites the oldest record: the count stays at CAP and never exceeds it.
- R12: A write and a read in the same cycle on a non-empty FIFO leave the count unchanged.
- R13: A read strobe on an empty FIFO is ignored. A write together with a read on an empty FIFO gives a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_wr | input | 1 | One record written into the FIFO |
| smp_rd | input | 1 | One record consumed from the FIFO |
| wtm_level | input | 9 | Watermark threshold in records |
| batch_tick | input | 1 | Batch counter increment strobe |
| batch_thresh | input | 11 | Batch counter threshold |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read address |
| reg_rd_data | output | 8 | Register read data |
| stat_lo | output | 8 | Status byte 1 (count[7:0]) |
| stat_hi | output | 8 | Status byte 2 (flags and count[9:8]) |
| lvl_wtm | output | 1 | Watermark reached |
| lvl_full | output | 1 | FIFO completely filled |
| lvl_full_next | output | 1 | FIFO full after the next write |

## Verification
The bench uses a 12-record capacity. For every watermark from 0 to 14 it fills past full and drains past empty, and for each batch threshold from 0 to 5 it steps the batch counter through its wrap. These sweeps are followed by a long pseudo-random mix. It targets the following corner cases:
- Overwrite at full: a count that wraps or grows past capacity would corrupt the full and full-next flags.
- Read at empty: a design that let this read through would underflow to 1023.
- Simultaneous read and write: a design that got this wrong would step the count.
- Sticky-flag clear racing a new set: a design that let the clear win would drop an overrun or batch event.
- Read data in the clearing cycle: a design that cleared first would return the flag already cleared.

// File: rtl/sfifo_stat_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register addresses and the status-byte-2 layout
// for the sensor FIFO status unit. Assumes an 8-bit register address space.
package sfifo_stat_pkg;
    localparam int CNT_W   = 10;
    localparam int WTM_W   = 9;
    localparam int BATCH_W = 11;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] A_STAT_LO = 8'h3A;
    localparam logic [ADDR_W-1:0] A_STAT_HI = 8'h3B;
    localparam logic [ADDR_W-1:0] A_BTH_LO  = 8'h0B;
    localparam logic [ADDR_W-1:0] A_BTH_HI  = 8'h0C;

    // Status byte 2, MSB first; the order is the register layout.
    typedef struct packed {
        logic       wtm;
        logic       full;
        logic       full_nx;
        logic       batch;
        logic       ovr_lat;
        logic       rsvd;
        logic [1:0] cnt_hi;
    } stat_hi_t;
endpackage

// File: rtl/sfifo_level_track.sv
`timescale 1ns/1ps
// Module: sfifo_level_track
// Keeps the unread record count of the sample FIFO. A write at full
// overwrites the oldest record (count held, overrun pulse). A read on an
// empty FIFO is dropped. Assumes CAP fits in CNT_W bits and CAP >= 2.
module sfifo_level_track
    import sfifo_stat_pkg::*;
#(
    parameter int CAP = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr_evt
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    logic rd_eff;
    logic at_cap;

    // Decode the effective read and the overwrite condition.
    always_comb begin
        rd_eff  = rd && (cnt != '0);
        at_cap  = (cnt == CAP_V);
        ovr_evt = wr && !rd_eff && at_cap;
    end

    // Advance the count; a matched write/read pair leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr && !rd_eff && !at_cap) begin
            cnt <= cnt + 1'b1;
        end else if (!wr && rd_eff) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sfifo_batch_flag.sv
`timescale 1ns/1ps
// Module: sfifo_batch_flag
// Batch counter that counts increment strobes and raises a sticky flag
// when the incremented value equals the threshold, then restarts at 0.
// The flag clears on clr; a set in the same cycle wins. Threshold 0
// never matches because the compare is one bit wider than the counter.
module sfifo_batch_flag
    import sfifo_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [BATCH_W-1:0] thresh,
    input  logic               clr,
    output logic               flag
);
    logic [BATCH_W-1:0] bcnt;
    logic [BATCH_W:0]   bnext;
    logic               hit;

    // Form the incremented value and the threshold match.
    always_comb begin
        bnext = {1'b0, bcnt} + 1'b1;
        hit   = tick && (bnext == {1'b0, thresh});
    end

    // Step the counter, restarting it on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (tick) begin
            bcnt <= hit ? '0 : bnext[BATCH_W-1:0];
        end
    end

    // Keep the sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sfifo_stat_regs.sv
`timescale 1ns/1ps
// Module: sfifo_stat_regs
// Derives the level flags, holds the latched overrun flag, packs the two
// status bytes and serves the read port. It also decodes the read addresses
// that clear the sticky flags. Read data is combinational from the state
// before the clear, so a clearing read returns the flag still set.
module sfifo_stat_regs
    import sfifo_stat_pkg::*;
#(
    parameter int CAP = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovr_evt,
    input  logic              batch_flag,
    input  logic [WTM_W-1:0]  wtm,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              batch_clr,
    output logic [DATA_W-1:0] stat_lo,
    output logic [DATA_W-1:0] stat_hi,
    output logic              f_wtm,
    output logic              f_full,
    output logic              f_full_nx
);
    localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] CAPM_V = CNT_W'(CAP - 1);

    logic     ovr_lat;
    logic     hi_clr;
    stat_hi_t hi_s;

    // Level flags from the current count.
    always_comb begin
        f_wtm     = (cnt >= {{(CNT_W-WTM_W){1'b0}}, wtm});
        f_full    = (cnt == CAP_V);
        f_full_nx = (cnt == CAPM_V);
    end

    // Decode the clear-on-read addresses.
    always_comb begin
        hi_clr    = rd_en && (rd_addr == A_STAT_HI);
        batch_clr = rd_en && ((rd_addr == A_BTH_LO) || (rd_addr == A_BTH_HI));
    end

    // Hold the latched overrun flag; a new overrun beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_lat <= 1'b0;
        end else if (ovr_evt) begin
            ovr_lat <= 1'b1;
        end else if (hi_clr) begin
            ovr_lat <= 1'b0;
        end
    end

    // Pack both status bytes.
    always_comb begin
        hi_s.wtm     = f_wtm;
        hi_s.full    = f_full;
        hi_s.full_nx = f_full_nx;
        hi_s.batch   = batch_flag;
        hi_s.ovr_lat = ovr_lat;
        hi_s.rsvd    = 1'b0;
        hi_s.cnt_hi  = cnt[CNT_W-1:DATA_W];
        stat_lo      = cnt[DATA_W-1:0];
        stat_hi      = hi_s;
    end

    // Register read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == A_STAT_LO) rd_data = stat_lo;
            else if (rd_addr == A_STAT_HI) rd_data = stat_hi;
        end
    end
endmodule

// File: rtl/sfifo_status_unit.sv
`timescale 1ns/1ps
// Module: sfifo_status_unit (top)
// Tracks the unread record count of a sensor sample FIFO. Exposes it with
// the watermark, full, full-next, latched overrun and batch flags in two
// read-only status bytes. Assumes strobes are single-cycle and synchronous
// to clk, and that CAP is between 2 and 1023.
module sfifo_status_unit
    import sfifo_stat_pkg::*;
#(
    parameter int CAP = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_wr,
    input  logic                   smp_rd,
    input  logic [WTM_W-1:0]       wtm_level,
    input  logic                   batch_tick,
    input  logic [BATCH_W-1:0]     batch_thresh,
    input  logic                   reg_rd_en,
    input  logic [ADDR_W-1:0]      reg_rd_addr,
    output logic [DATA_W-1:0]      reg_rd_data,
    output logic [DATA_W-1:0]      stat_lo,
    output logic [DATA_W-1:0]      stat_hi,
    output logic                   lvl_wtm,
    output logic                   lvl_full,
    output logic                   lvl_full_next
);
    logic [CNT_W-1:0] cnt;
    logic             ovr_evt;
    logic             batch_flag;
    logic             batch_clr;

    sfifo_level_track #(.CAP(CAP)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (smp_wr),
        .rd      (smp_rd),
        .cnt     (cnt),
        .ovr_evt (ovr_evt)
    );

    sfifo_batch_flag u_batch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (batch_tick),
        .thresh (batch_thresh),
        .clr    (batch_clr),
        .flag   (batch_flag)
    );

    sfifo_stat_regs #(.CAP(CAP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .ovr_evt    (ovr_evt),
        .batch_flag (batch_flag),
        .wtm        (wtm_level),
        .rd_en      (reg_rd_en),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .batch_clr  (batch_clr),
        .stat_lo    (stat_lo),
        .stat_hi    (stat_hi),
        .f_wtm      (lvl_wtm),
        .f_full     (lvl_full),
        .f_full_nx  (lvl_full_next)
    );
endmodule

// File: rtl/sfifo_status_unit_chk.sv
`timescale 1ns/1ps
// Module: sfifo_status_unit_chk
// Assertion checker bound to the top. It observes ports only and
// rebuilds the count from the two status bytes.
module sfifo_status_unit_chk
    import sfifo_stat_pkg::*;
#(
    parameter int CAP = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_wr,
    input logic              smp_rd,
    input logic              batch_tick,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_rd_addr,
    input logic [DATA_W-1:0] stat_lo,
    input logic [DATA_W-1:0] stat_hi
);
    logic [CNT_W-1:0] cnt;
    assign cnt = {stat_hi[1:0], stat_lo};

    // R11: the count never passes capacity
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CAP));

    // R12: matched write and read on a non-empty FIFO hold the count
    a_r12_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_wr && smp_rd && cnt != '0) |=> $stable(cnt));

    // R13: a lone read of an empty FIFO is dropped
    a_r13_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_rd && !smp_wr && cnt == '0) |=> (cnt == '0));

    // R6: an overwrite at full sets the latched overrun bit
    a_r6_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_wr && !smp_rd && cnt == CNT_W'(CAP)) |=> stat_hi[3]);

    // R6: the latched bit holds without a status-byte-2 read
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hi[3] && !(reg_rd_en && reg_rd_addr == A_STAT_HI)) |=> stat_hi[3]);

    // R8: a threshold-address read with no increment clears the batch flag
    a_r8_batch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_rd_addr == A_BTH_LO && !batch_tick) |=> !stat_hi[4]);

    // R2: the reserved bit of status byte 2 reads 0
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_hi[2]);

    // R5: from one below capacity a lone write makes the FIFO full
    a_r5_next_full: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hi[5] && smp_wr && !smp_rd) |=> stat_hi[6]);
endmodule

bind sfifo_status_unit sfifo_status_unit_chk #(.CAP(CAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_wr      (smp_wr),
    .smp_rd      (smp_rd),
    .batch_tick  (batch_tick),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr),
    .stat_lo     (stat_lo),
    .stat_hi     (stat_hi)
);

// File: tb/sfifo_status_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps watermark and batch thresholds on a 12-record FIFO and
// compares every output against an arithmetic model after each cycle.
module sfifo_status_unit_bench;
    localparam int CAP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_wr = 1'b0, smp_rd = 1'b0, batch_tick = 1'b0, reg_rd_en = 1'b0;
    logic [8:0]  wtm_level = '0;
    logic [10:0] batch_thresh = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [7:0]  reg_rd_data, stat_lo, stat_hi;
    logic        lvl_wtm, lvl_full, lvl_full_next;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    int m_cnt = 0, m_bcnt = 0;
    bit m_lat = 0, m_bf = 0;

    always #10 clk = ~clk;

    sfifo_status_unit #(.CAP(CAP)) u_sfifo_status_unit (
        .clk(clk), .rst_n(rst_n), .smp_wr(smp_wr), .smp_rd(smp_rd),
        .wtm_level(wtm_level), .batch_tick(batch_tick), .batch_thresh(batch_thresh),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .stat_lo(stat_lo), .stat_hi(stat_hi), .lvl_wtm(lvl_wtm),
        .lvl_full(lvl_full), .lvl_full_next(lvl_full_next)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hi();
        exp_hi = {m_cnt >= int'(wtm_level), m_cnt == CAP, m_cnt == CAP - 1,
                  m_bf, m_lat, 1'b0, 2'(m_cnt >> 8)};
    endfunction

    task automatic check_state(input string cnt_tag);
        chk(cnt_tag, {24'd0, stat_lo}, 32'(m_cnt & 255));
        chk("R1 hi", {30'd0, stat_hi[1:0]}, 32'(m_cnt >> 8));
        chk("R2 rsvd", {31'd0, stat_hi[2]}, 32'd0);
        chk("R3 wtm", {30'd0, stat_hi[7], lvl_wtm}, {30'd0, {2{m_cnt >= int'(wtm_level)}}});
        chk("R4 full", {30'd0, stat_hi[6], lvl_full}, {30'd0, {2{m_cnt == CAP}}});
        chk("R5 fullnx", {30'd0, stat_hi[5], lvl_full_next}, {30'd0, {2{m_cnt == CAP - 1}}});
        chk("R6 latch", {31'd0, stat_hi[3]}, {31'd0, m_lat});
        chk("R7 R8 batch", {31'd0, stat_hi[4]}, {31'd0, m_bf});
    endtask

    // one clock cycle: drive, check read data, clock, update model, check
    task automatic step(input bit w, input bit r, input bit t, input bit re, input logic [7:0] a);
        bit eff_rd, ovr, hit;
        int nx;
        string tag;
        logic [7:0] exp_rd;
        @(negedge clk);
        smp_wr = w; smp_rd = r; batch_tick = t; reg_rd_en = re; reg_rd_addr = a;
        #1;
        exp_rd = !re ? 8'h00 : (a == 8'h3A) ? 8'(m_cnt & 255) : (a == 8'h3B) ? exp_hi() : 8'h00;
        chk("R9 rdata", {24'd0, reg_rd_data}, {24'd0, exp_rd});
        eff_rd = r && m_cnt != 0;
        ovr = w && !eff_rd && m_cnt == CAP;
        tag = ovr ? "R11 overwrite" : (w && r && m_cnt != 0) ? "R12 pair" :
              (r && m_cnt == 0) ? "R13 empty read" : "R1 count";
        @(posedge clk);
        if (w && !eff_rd && m_cnt < CAP) m_cnt++;
        else if (!w && eff_rd) m_cnt--;
        if (ovr) m_lat = 1;
        else if (re && a == 8'h3B) m_lat = 0;
        hit = 0;
        if (t) begin
            nx = m_bcnt + 1;
            hit = (nx == int'(batch_thresh));
            m_bcnt = hit ? 0 : (nx & 2047);
        end
        if (hit) m_bf = 1;
        else if (re && (a == 8'h0B || a == 8'h0C)) m_bf = 0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R10: reset dominates active strobes
        smp_wr = 1; batch_tick = 1; batch_thresh = 11'd1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset lo", {24'd0, stat_lo}, 32'd0);
        chk("R10 reset hi", {24'd0, stat_hi}, {24'd0, 8'h80});
        @(negedge clk);
        smp_wr = 0; batch_tick = 0; batch_thresh = 0; wtm_level = 9'd1;
        #1;
        chk("R10 reset flags", {24'd0, stat_hi}, 32'd0);
        rst_n = 1;

        // Watermark sweep with fill past full and drain past empty.
        for (int wv = 0; wv <= CAP + 2; wv++) begin
            wtm_level = 9'(wv);
            for (int i = 0; i < CAP + 3; i++)
                step(1, 0, 0, (i % 4) == 3, 8'h3B);
            step(1, 0, 0, 1, 8'h3B);     // R6: overrun and clear in one cycle
            step(1, 1, 0, 0, 8'h00);     // R12 at full
            step(0, 0, 0, 1, 8'h3B);     // R6: clearing read
            step(0, 0, 0, 1, 8'h3B);
            for (int i = 0; i < CAP + 2; i++)
                step(0, 1, 0, 1, (i % 2) ? 8'h3A : 8'h3B);
            step(1, 1, 0, 0, 8'h00);     // R13: pair on empty gives 1
            step(0, 1, 0, 0, 8'h00);
        end

        // Batch threshold sweep, including a set racing a clear (R8).
        for (int tv = 0; tv <= 5; tv++) begin
            batch_thresh = 11'(tv);
            for (int i = 0; i < 14; i++)
                step(0, 0, 1, (i % 3) == 2, (i % 2) ? 8'h0B : 8'h0C);
            step(0, 0, 0, 1, 8'h0C);
            step(0, 0, 0, 1, 8'h55);     // R9: unknown address reads 0
        end

        // Pseudo-random mix.
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:12] == 4'h0) wtm_level = 9'(lf[3:0]);
            if (lf[15:12] == 4'h1) batch_thresh = 11'(lf[2:0]);
            step(lf[0] | lf[5], lf[1] & lf[6], lf[2],
                 lf[3], lf[4] ? (lf[7] ? 8'h3B : 8'h3A) : (lf[7] ? 8'h0B : 8'h0C));
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end
endmodule